// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers interrupt requests for a small CPU core and decides, at each instruction boundary, which single request the core should service next. Peripheral requests arrive as flag/enable bit pairs. Several pairs may feed one interrupt id, and a pair is only active when both its flag and its enable are high. Sources wired without an enable are active on the flag alone. Software-trap, illegal-opcode and non-maskable requests arrive as one-cycle raise strobes. All requests accumulate in a 32-bit pending register.

When the core signals an instruction boundary, a combinational arbiter looks at the pending register and the core's two mask bits. The software trap wins over everything else, and the illegal-opcode trap comes next; neither can be masked. After them comes the non-maskable request, which only the X mask bit can hold back. Peripheral ids come last and the I mask bit gates them, with the lowest pending id winning. The grant is registered. It gives the id and the vector fetch address, whose base changes in the bootstrap strap mode. It also tells the core which mask bit to raise. An entry timer then holds off further grants for the fixed 14-cycle entry cost.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted and right after it, take_vld, set_i_req, set_x_req and entry_busy are 0 and no id is pending, so a boundary with no request grants nothing.
- R2: A peripheral pair makes its id pending only when its flag and its enable are both 1. A pair configured without an enable needs its flag alone. The pending register follows the pairs one clock after they change.
- R3: When several pairs share one id, that id stays pending while any one of them is active and is dropped only when all of them are inactive.
- R4: A grant is made only on a clock edge where insn_end is 1. take_vld is then 1 for exactly the following cycle, together with take_id.
- R5: A pending software trap (id 27) is granted before anything else, and a pending illegal-opcode trap (id 28) is granted next, whatever ccr_i and ccr_x are. Granting either one clears its pending bit.
- R6: A pending non-maskable request (id 26) is granted when ccr_x is 0, and the grant clears its pending bit. While it is pending and ccr_x is 1, no id at all is granted.
- R7: While ccr_i is 1 no peripheral id is granted. Otherwise the lowest-numbered pending peripheral id is granted, and it stays pending for as long as its source is active.
- R8: A grant of id 26 raises set_x_req. Every other grant raises set_i_req. Both are 0 in cycles without a grant.
- R9: On a grant, vec_addr equals the base plus twice take_id. The base is 16'hFFC0 when boot_mode was 0 at the granting edge and 16'hBFC0 when it was 1.
- R10: entry_busy is 1 for the 14 cycles that start with the grant cycle. Boundaries seen while it is 1 grant nothing and leave the pending bits as they were.
- R11: A raise strobe that arrives on the same edge as the grant of that trap id leaves the id pending, so it is granted again at the next allowed boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flag | input | NUM_SRC (8) | Peripheral request flags; default map: sources 0-3 to id 4, 4 to id 5, 5 to id 6, 6 to id 7, 7 to id 9 |
| src_en | input | NUM_SRC (8) | Peripheral enable bits (source 7 has none by default) |
| swtrap_raise | input | 1 | One-cycle raise of the software trap |
| illop_raise | input | 1 | One-cycle raise of the illegal-opcode trap |
| nmi_raise | input | 1 | One-cycle raise of the non-maskable request |
| insn_end | input | 1 | Instruction boundary strobe |
| ccr_i | input | 1 | CPU maskable-interrupt mask bit |
| ccr_x | input | 1 | CPU non-maskable-request mask bit |
| boot_mode | input | 1 | Bootstrap strap selecting the alternate vector base |
| take_vld | output | 1 | Grant strobe |
| take_id | output | 5 | Granted interrupt id |
| vec_addr | output | 16 | Address of the granted vector |
| set_i_req | output | 1 | Request to set the I mask bit |
| set_x_req | output | 1 | Request to set the X mask bit |
| entry_busy | output | 1 | Entry cost window in progress |

## Verification
A change on a flag, an enable or a raise strobe reaches the pending register at the next edge. A grant from that state appears in the cycle after the edge on which insn_end is sampled, so the shortest path from flag to take_vld is two edges. entry_busy rises together with take_vld and falls 14 cycles later. The bench keeps a cycle-level model that applies these latencies: it drives inputs 1 ns after an edge, computes the expected outputs for the next edge, and compares 1 ns after that edge. Every grant, set request, vector and busy value is therefore checked on the exact cycle it is due.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_IDS = 32;
  localparam int ID_W    = $clog2(NUM_IDS);

  typedef logic [NUM_IDS-1:0] id_mask_t;
  typedef logic [ID_W-1:0]    id_t;

  typedef struct packed {
    logic     hit;
    id_t      id;
    logic     to_x;
    id_mask_t clr;
  } grant_t;
endpackage

// File: rtl/irqc_src_gather.sv
module irqc_src_gather
  import irqc_pkg::*;
#(
  parameter int                        NUM_SRC    = 8,
  parameter logic [NUM_SRC*ID_W-1:0]   SRC_ID_MAP = '0,
  parameter logic [NUM_SRC-1:0]        SRC_HAS_EN = '1
) (
  input  logic [NUM_SRC-1:0] flag,
  input  logic [NUM_SRC-1:0] en,
  output id_mask_t           set_mask,
  output id_mask_t           clr_mask
);
  logic [NUM_SRC-1:0] act;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_pair
    if (SRC_HAS_EN[s]) begin : g_gated
      assign act[s] = flag[s] & en[s];
    end else begin : g_flag_only
      assign act[s] = flag[s];
    end
  end

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (act[s]) set_mask[SRC_ID_MAP[s*ID_W +: ID_W]] = 1'b1;
      else        clr_mask[SRC_ID_MAP[s*ID_W +: ID_W]] = 1'b1;
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter id_t ID_NMI    = id_t'(26),
  parameter id_t ID_SWTRAP = id_t'(27),
  parameter id_t ID_ILLOP  = id_t'(28)
) (
  input  id_mask_t pend,
  input  logic     ccr_i,
  input  logic     ccr_x,
  output grant_t   grant
);
  localparam id_mask_t SPECIAL = (id_mask_t'(1) << ID_NMI)
                               | (id_mask_t'(1) << ID_SWTRAP)
                               | (id_mask_t'(1) << ID_ILLOP);

  id_mask_t maskable;
  logic     pick_hit;
  id_t      pick_id;

  assign maskable = pend & ~SPECIAL;

  always_comb begin
    pick_hit = 1'b0;
    pick_id  = '0;
    for (int k = NUM_IDS - 1; k >= 0; k--) begin
      if (maskable[k]) begin
        pick_hit = 1'b1;
        pick_id  = id_t'(k);
      end
    end
  end

  always_comb begin
    grant = '0;
    if (pend[ID_SWTRAP]) begin
      grant.hit = 1'b1;
      grant.id  = ID_SWTRAP;
      grant.clr = id_mask_t'(1) << ID_SWTRAP;
    end else if (pend[ID_ILLOP]) begin
      grant.hit = 1'b1;
      grant.id  = ID_ILLOP;
      grant.clr = id_mask_t'(1) << ID_ILLOP;
    end else if (pend[ID_NMI]) begin
      if (!ccr_x) begin
        grant.hit  = 1'b1;
        grant.id   = ID_NMI;
        grant.to_x = 1'b1;
        grant.clr  = id_mask_t'(1) << ID_NMI;
      end
    end else if (!ccr_i && pick_hit) begin
      grant.hit = 1'b1;
      grant.id  = pick_id;
    end
  end
endmodule

// File: rtl/irqc_entry_timer.sv
module irqc_entry_timer #(
  parameter int COST = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(COST + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = CW'(COST);
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int                      NUM_SRC       = 8,
  parameter logic [NUM_SRC*ID_W-1:0] SRC_ID_MAP    = {5'd9, 5'd7, 5'd6, 5'd5,
                                                      5'd4, 5'd4, 5'd4, 5'd4},
  parameter logic [NUM_SRC-1:0]      SRC_HAS_EN    = 8'b0111_1111,
  parameter id_t                     ID_NMI        = id_t'(26),
  parameter id_t                     ID_SWTRAP     = id_t'(27),
  parameter id_t                     ID_ILLOP      = id_t'(28),
  parameter int                      VEC_W         = 16,
  parameter logic [VEC_W-1:0]        VEC_BASE_NORM = 16'hFFC0,
  parameter logic [VEC_W-1:0]        VEC_BASE_BOOT = 16'hBFC0,
  parameter int                      ENTRY_COST    = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_flag,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               swtrap_raise,
  input  logic               illop_raise,
  input  logic               nmi_raise,
  input  logic               insn_end,
  input  logic               ccr_i,
  input  logic               ccr_x,
  input  logic               boot_mode,
  output logic               take_vld,
  output logic [ID_W-1:0]    take_id,
  output logic [VEC_W-1:0]   vec_addr,
  output logic               set_i_req,
  output logic               set_x_req,
  output logic               entry_busy
);
  id_mask_t         pend_q, pend_d;
  id_mask_t         p_set, p_clr, raise_vec;
  grant_t           grant;
  logic             fire;
  logic             take_d, seti_d, setx_d;
  id_t              id_q, id_d;
  logic [VEC_W-1:0] vec_q, vec_d, base;

  irqc_src_gather #(
    .NUM_SRC   (NUM_SRC),
    .SRC_ID_MAP(SRC_ID_MAP),
    .SRC_HAS_EN(SRC_HAS_EN)
  ) u_gather (
    .flag    (src_flag),
    .en      (src_en),
    .set_mask(p_set),
    .clr_mask(p_clr)
  );

  irqc_arbiter #(
    .ID_NMI   (ID_NMI),
    .ID_SWTRAP(ID_SWTRAP),
    .ID_ILLOP (ID_ILLOP)
  ) u_arb (
    .pend (pend_q),
    .ccr_i(ccr_i),
    .ccr_x(ccr_x),
    .grant(grant)
  );

  irqc_entry_timer #(
    .COST(ENTRY_COST)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (fire),
    .busy (entry_busy)
  );

  assign fire = insn_end & ~entry_busy & grant.hit;
  assign base = boot_mode ? VEC_BASE_BOOT : VEC_BASE_NORM;

  always_comb begin
    raise_vec = '0;
    raise_vec[ID_SWTRAP] = swtrap_raise;
    raise_vec[ID_ILLOP]  = illop_raise;
    raise_vec[ID_NMI]    = nmi_raise;
  end

  // next state: grant clear and inactive pairs first, then set
  always_comb begin
    pend_d = pend_q & ~p_clr;
    if (fire) pend_d = pend_d & ~grant.clr;
    pend_d = pend_d | p_set | raise_vec;
    take_d = fire;
    seti_d = fire & ~grant.to_x;
    setx_d = fire & grant.to_x;
    id_d   = id_q;
    vec_d  = vec_q;
    if (fire) begin
      id_d  = grant.id;
      vec_d = base + VEC_W'({grant.id, 1'b0});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      take_vld  <= 1'b0;
      set_i_req <= 1'b0;
      set_x_req <= 1'b0;
      id_q      <= '0;
      vec_q     <= '0;
    end else begin
      pend_q    <= pend_d;
      take_vld  <= take_d;
      set_i_req <= seti_d;
      set_x_req <= setx_d;
      id_q      <= id_d;
      vec_q     <= vec_d;
    end
  end

  assign take_id  = id_q;
  assign vec_addr = vec_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter id_t              ID_NMI        = id_t'(26),
  parameter id_t              ID_SWTRAP     = id_t'(27),
  parameter id_t              ID_ILLOP      = id_t'(28),
  parameter int               VEC_W         = 16,
  parameter logic [VEC_W-1:0] VEC_BASE_NORM = 16'hFFC0,
  parameter logic [VEC_W-1:0] VEC_BASE_BOOT = 16'hBFC0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_end,
  input logic             ccr_i,
  input logic             ccr_x,
  input logic             boot_mode,
  input logic             take_vld,
  input id_t              take_id,
  input logic [VEC_W-1:0] vec_addr,
  input logic             set_i_req,
  input logic             set_x_req,
  input logic             entry_busy
);
  logic maskable_take;
  assign maskable_take = take_vld && take_id != ID_NMI
                         && take_id != ID_SWTRAP && take_id != ID_ILLOP;

  AST_TAKE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_vld |-> $past(insn_end)); // R4
  AST_TAKE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_vld |=> !take_vld); // R4
  AST_MASK_REQ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    take_vld |-> $onehot({set_i_req, set_x_req})); // R8
  AST_MASK_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take_vld |-> !set_i_req && !set_x_req); // R8
  AST_NMI_SETS_X: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vld && take_id == ID_NMI) |-> set_x_req); // R8
  AST_NMI_NEEDS_X_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vld && take_id == ID_NMI) |-> !$past(ccr_x)); // R6
  AST_MASKABLE_NEEDS_I_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    maskable_take |-> !$past(ccr_i)); // R7
  AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    take_vld |-> vec_addr == (($past(boot_mode) ? VEC_BASE_BOOT : VEC_BASE_NORM)
                              + VEC_W'({take_id, 1'b0}))); // R9
  AST_ENTRY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    take_vld |-> !$past(entry_busy)); // R10
  AST_ENTRY_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    take_vld |-> entry_busy); // R10
endmodule

bind irq_prio_ctrl irqc_chk #(
  .ID_NMI       (ID_NMI),
  .ID_SWTRAP    (ID_SWTRAP),
  .ID_ILLOP     (ID_ILLOP),
  .VEC_W        (VEC_W),
  .VEC_BASE_NORM(VEC_BASE_NORM),
  .VEC_BASE_BOOT(VEC_BASE_BOOT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .insn_end  (insn_end),
  .ccr_i     (ccr_i),
  .ccr_x     (ccr_x),
  .boot_mode (boot_mode),
  .take_vld  (take_vld),
  .take_id   (take_id),
  .vec_addr  (vec_addr),
  .set_i_req (set_i_req),
  .set_x_req (set_x_req),
  .entry_busy(entry_busy)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int ID_NMI = 26, ID_SW = 27, ID_ILL = 28, COST = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  src_flag, src_en;
  logic        swtrap_raise, illop_raise, nmi_raise, insn_end;
  logic        ccr_i, ccr_x, boot_mode;
  logic        take_vld, set_i_req, set_x_req, entry_busy;
  logic [4:0]  take_id;
  logic [15:0] vec_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [31:0] m_pend;
  int          m_cnt;

  always #5 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .swtrap_raise(swtrap_raise), .illop_raise(illop_raise), .nmi_raise(nmi_raise),
    .insn_end(insn_end), .ccr_i(ccr_i), .ccr_x(ccr_x), .boot_mode(boot_mode),
    .take_vld(take_vld), .take_id(take_id), .vec_addr(vec_addr),
    .set_i_req(set_i_req), .set_x_req(set_x_req), .entry_busy(entry_busy)
  );

  function automatic int map_id(int s);
    if (s < 4) return 4;
    if (s == 4) return 5;
    if (s == 5) return 6;
    if (s == 6) return 7;
    return 9;
  endfunction

  // R5 R6 R7 ordering as stated in the requirements
  task automatic decide(input logic [31:0] p, input logic i, input logic x,
                        output logic hit, output int id, output logic tox,
                        output logic [31:0] clr);
    hit = 0; id = 0; tox = 0; clr = '0;
    if (p[ID_SW]) begin hit = 1; id = ID_SW; clr[ID_SW] = 1; end
    else if (p[ID_ILL]) begin hit = 1; id = ID_ILL; clr[ID_ILL] = 1; end
    else if (p[ID_NMI]) begin
      if (!x) begin hit = 1; id = ID_NMI; tox = 1; clr[ID_NMI] = 1; end
    end else if (!i) begin
      for (int k = 0; k < 32; k++)
        if (!hit && p[k] && k != ID_NMI && k != ID_SW && k != ID_ILL) begin
          hit = 1; id = k;
        end
    end
  endtask

  task automatic fail_line(input string tag, input string what, input int got, input int exp);
    n_bad++;
    $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
  endtask

  task automatic tick(input string tag);
    logic [31:0] pset, pclr, tclr, nxt;
    logic hit, tox, fire;
    int id, ncnt;
    logic [15:0] evec;
    pset = '0; pclr = '0; hit = 0; tox = 0; id = 0; tclr = '0;
    for (int s = 0; s < 8; s++) begin
      if (src_flag[s] && (src_en[s] || s == 7)) pset[map_id(s)] = 1;
      else                                      pclr[map_id(s)] = 1;
    end
    decide(m_pend, ccr_i, ccr_x, hit, id, tox, tclr);
    fire = rst_n && insn_end && (m_cnt == 0) && hit;
    nxt  = m_pend & ~pclr;
    if (fire) nxt = nxt & ~tclr;
    nxt = nxt | pset;
    nxt[ID_SW]  = nxt[ID_SW]  | swtrap_raise;
    nxt[ID_ILL] = nxt[ID_ILL] | illop_raise;
    nxt[ID_NMI] = nxt[ID_NMI] | nmi_raise;
    ncnt = fire ? COST : (m_cnt > 0 ? m_cnt - 1 : 0);
    evec = (boot_mode ? 16'hBFC0 : 16'hFFC0) + 16'(2 * id);
    if (!rst_n) begin nxt = '0; ncnt = 0; end
    @(posedge clk); #1;
    n_chk++;
    if (take_vld !== fire || (fire && take_id !== 5'(id)))
      fail_line(tag, "take vld*64+id", take_vld ? 64 + int'(take_id) : 0, fire ? 64 + id : 0);
    n_chk++;
    if ({set_i_req, set_x_req} !== {fire & ~tox, fire & tox})
      fail_line("R8", "set_i*2+set_x", int'({set_i_req, set_x_req}), int'({fire & ~tox, fire & tox}));
    if (fire) begin
      n_chk++;
      if (vec_addr !== evec) fail_line("R9", "vec_addr", int'(vec_addr), int'(evec));
    end
    n_chk++;
    if (entry_busy !== (ncnt != 0)) fail_line("R10", "entry_busy", int'(entry_busy), int'(ncnt != 0));
    m_pend = nxt; m_cnt = ncnt;
    swtrap_raise = 0; illop_raise = 0; nmi_raise = 0; insn_end = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  task automatic bnd(input string tag);
    insn_end = 1; tick(tag);
  endtask

  initial begin
    rst_n = 0; src_flag = 0; src_en = 0; swtrap_raise = 0; illop_raise = 0;
    nmi_raise = 0; insn_end = 0; ccr_i = 0; ccr_x = 0; boot_mode = 0;
    m_pend = '0; m_cnt = 0;
    void'($urandom(32'd4711));
    #1;
    idle(3, "R1");
    rst_n = 1;
    tick("R1");
    bnd("R1");                                  // nothing pending
    // R2: flag without enable, then enable
    src_flag[0] = 1; tick("R2"); bnd("R2");
    src_en[0] = 1; tick("R2"); bnd("R2"); idle(COST, "R2");
    src_flag = 0; src_en = 0;
    src_flag[7] = 1; tick("R2"); bnd("R2"); idle(COST, "R2");
    src_flag = 0; tick("R2");
    // R3: shared id held by one remaining pair
    src_flag[1:0] = 2'b11; src_en[1:0] = 2'b11; tick("R3");
    src_flag[0] = 0; tick("R3"); bnd("R3"); idle(COST, "R3");
    src_en[1] = 0; tick("R3"); bnd("R3");
    src_flag = 0; src_en = 0; tick("R3");
    // R5 R6: traps ignore masks, nmi blocked by X
    ccr_i = 1; ccr_x = 1; src_flag[4] = 1; src_en[4] = 1;
    swtrap_raise = 1; illop_raise = 1; nmi_raise = 1; tick("R5");
    bnd("R5"); idle(COST, "R5");
    bnd("R5"); idle(COST, "R5");
    ccr_i = 0; bnd("R6"); idle(3, "R6");
    ccr_x = 0; bnd("R6"); idle(COST, "R6");
    // R7: I gating, lowest id, stays pending
    ccr_i = 1; bnd("R7"); tick("R7");
    ccr_i = 0; src_flag[6] = 1; src_en[6] = 1; tick("R7");
    bnd("R7"); idle(COST, "R7");
    bnd("R7"); idle(COST, "R7");
    src_flag[4] = 0; tick("R7"); bnd("R7"); idle(COST, "R7");
    // R9: bootstrap vector base
    boot_mode = 1; bnd("R9"); idle(COST, "R9"); boot_mode = 0;
    src_flag = 0; src_en = 0; tick("R9");
    // R10: boundaries during entry window
    nmi_raise = 1; tick("R10"); bnd("R10");
    swtrap_raise = 1; tick("R10");
    for (int k = 0; k < COST; k++) bnd("R10");
    idle(COST, "R10");
    // R11: raise on the granting edge
    swtrap_raise = 1; tick("R11");
    swtrap_raise = 1; bnd("R11"); idle(COST - 1, "R11");
    bnd("R11"); idle(COST, "R11"); bnd("R11");
    idle(COST, "R11");
    // random mix
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 5) == 0) src_flag[$urandom_range(0, 7)] ^= 1'b1;
      if ($urandom_range(0, 7) == 0) src_en[$urandom_range(0, 7)] ^= 1'b1;
      swtrap_raise = ($urandom_range(0, 60) == 0);
      illop_raise  = ($urandom_range(0, 60) == 0);
      nmi_raise    = ($urandom_range(0, 40) == 0);
      insn_end     = ($urandom_range(0, 1) == 0);
      ccr_i        = ($urandom_range(0, 1) == 0);
      if ($urandom_range(0, 15) == 0) ccr_x = ~ccr_x;
      boot_mode    = ($urandom_range(0, 3) == 0);
      tick("R7");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule